// File: doc/BRIEF.md
# Quadlet-buffered host register interface

This block connects a narrow microprocessor bus to a bank of 32-bit internal registers. The host bus has active-low chip select, read and write strobes, an address latch enable and a 9-bit address. Data moves one byte or one 16-bit halfword at a time, and the block gathers those pieces into a 32-bit staging register, or hands them out of it. Two static strap inputs set the data width (8 or 16 bits) and the address style: dedicated address lines, or the low address byte carried on the low data lines and captured by the latch enable.

Address bit 8 controls when data moves between the staging register and the bank. A read with bit 8 set copies the addressed register into staging; the block raises its hold output while that fetch is in progress. A write with bit 8 set stores the merged staging value into the addressed register. Narrow accesses with bit 8 clear only touch the staging register. When read and write strobes are both low under chip select, the block treats the access as a write, so a CPU with a single read/write line can drive the write strobe and tie the read strobe low.

Register index 0 is an interrupt status register. Its bits are set by the `irq_set` inputs and cleared by writing ones to them. Index 1 enables those bits onto the active-low interrupt output. The other implemented indices are plain storage.

Top module: `hostq_bridge`

## Requirements
- R1: After reset, `hold_o` is 0, `irq_n` is 1, `data_oe` is 0, and every internal register reads as zero.
- R2: In 8-bit mode (`wide_mode`=0), a write with `addr_lo[1:0]`=n places `data_in[7:0]` in staging bits [8n+7:8n]. A read returns that staging byte on `data_out[7:0]`, with `data_out[15:8]`=0.
- R3: In 16-bit mode (`wide_mode`=1), `addr_lo[1]`=0 selects staging bits [15:0] and `addr_lo[1]`=1 selects bits [31:16]. Data moves on all 16 data lines.
- R4: In multiplexed mode (`mux_mode`=1), the low eight address bits are taken from `data_in[7:0]` while `ale` is high, and are held after `ale` falls.
- R5: A write with `addr_ctl`=1 stores the merged staging quadlet into register `addr[7:2]`. Writes with `addr_ctl`=0 leave the bank unchanged. Indices at or above NREG discard writes and read zero.
- R6: A read with `addr_ctl`=1 copies register `addr[7:2]` into staging. `hold_o` is then high for exactly LAT (2) consecutive cycles. A read with `addr_ctl`=0 returns staging with no fetch and no hold.
- R7: With `cs_n`, `rd_n` and `wr_n` all low, the access is a write, and `data_oe` stays 0.
- R8: `data_oe` is 1 only while `cs_n`=0, `rd_n`=0 and `wr_n`=1.
- R9: Strobes have no effect while `cs_n` is high.
- R10: A high `irq_set[k]` sets status bit k (register 0). Writing a one to a status bit clears it, and setting wins over clearing. `irq_n` is low exactly when status AND enable (register 1) is nonzero.
- R11: Asserting `rst_n` low clears the outputs immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ale | input | 1 | Address latch enable (multiplexed mode) |
| wide_mode | input | 1 | Strap: 1 = 16-bit data path, 0 = 8-bit |
| mux_mode | input | 1 | Strap: 1 = low address byte on data_in[7:0] |
| addr_lo | input | 8 | Low address bits (non-multiplexed mode) |
| addr_ctl | input | 1 | Address bit 8: fetch on read, commit on write |
| data_in | input | 16 | Host write data (and multiplexed address) |
| data_out | output | 16 | Host read data |
| data_oe | output | 1 | Read data drive enable; 0 = bus released |
| hold_o | output | 1 | Wait request to the host, active high |
| irq_set | input | IRQ_W | Interrupt event pulses into status register |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The checks assume that the host keeps address, `addr_ctl` and data stable from before a strobe falls until at least three clock cycles after it rises. They also assume a multiplexed address stays on `data_in` for three cycles after `ale` falls, so that the synchronized strobes and latch enable see settled values. The bench drives every access through tasks that hold each phase for three or four cycles, and it changes the strap inputs only between accesses. The assertions also rely on the enable register not being written in the same cycle as an interrupt event, which the bench respects because it pulses `irq_set` only while the bus is idle.

// File: rtl/hq_pkg.sv
package hq_pkg;
  localparam int QW = 32;
  localparam int HW = 16;

  // merge host data into one lane of the staging quadlet
  function automatic logic [QW-1:0] lane_put(input logic [QW-1:0] q, input logic wide,
                                             input logic [1:0] a, input logic [HW-1:0] d);
    logic [QW-1:0] r;
    r = q;
    if (wide) begin
      if (a[1]) r[31:16] = d;
      else      r[15:0]  = d;
    end else begin
      case (a)
        2'd0:    r[7:0]   = d[7:0];
        2'd1:    r[15:8]  = d[7:0];
        2'd2:    r[23:16] = d[7:0];
        default: r[31:24] = d[7:0];
      endcase
    end
    return r;
  endfunction

  // select one lane of the staging quadlet for the host
  function automatic logic [HW-1:0] lane_get(input logic [QW-1:0] q, input logic wide,
                                             input logic [1:0] a);
    logic [HW-1:0] r;
    if (wide) r = a[1] ? q[31:16] : q[15:0];
    else begin
      case (a)
        2'd0:    r = {8'h00, q[7:0]};
        2'd1:    r = {8'h00, q[15:8]};
        2'd2:    r = {8'h00, q[23:16]};
        default: r = {8'h00, q[31:24]};
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/hq_sync.sv
module hq_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RV = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RV[i];
        s2_q <= RV[i];
      end else begin
        s1_q <= din[i];
        s2_q <= s1_q;
      end
    end
    assign dout[i] = s2_q;
  end
endmodule

// File: rtl/hq_front.sv
module hq_front #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          rd_s,
  input  logic          wr_s,
  input  logic          ale_s,
  input  logic          mux_mode,
  input  logic [7:0]    addr_lo,
  input  logic          addr_ctl,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_eff,
  output logic          rd_evt,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic [7:0]    alat_q, alat_d;
  logic          rd_q, wr_q, rd_act, wr_act;
  logic [AW-1:0] wa_q, wa_d;
  logic [DW-1:0] wd_q, wd_d;

  always_comb begin
    rd_act   = ~cs_s & ~rd_s & wr_s;
    wr_act   = ~cs_s & ~wr_s;
    alat_d   = (mux_mode && ale_s) ? data_in[7:0] : alat_q;
    addr_eff = {addr_ctl, (mux_mode ? alat_q : addr_lo)};
    wa_d     = wr_act ? addr_eff : wa_q;
    wd_d     = wr_act ? data_in : wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alat_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      alat_q <= alat_d;
      rd_q   <= rd_act;
      wr_q   <= wr_act;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
    end
  end

  assign rd_evt  = rd_act & ~rd_q;
  assign wr_evt  = wr_q & ~wr_act;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
endmodule

// File: rtl/hq_stage.sv
module hq_stage
  import hq_pkg::*;
#(
  parameter int LAT = 2,
  parameter int AW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [HW-1:0] wr_data,
  input  logic          fetch_go,
  input  logic [QW-1:0] fetch_data,
  output logic [QW-1:0] stage_q,
  output logic          commit,
  output logic [QW-1:0] commit_data,
  output logic          hold_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [QW-1:0] stage_d, pipe_q, pipe_d, merged;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    merged  = lane_put(stage_q, wide_mode, wr_addr[1:0], wr_data);
    stage_d = stage_q;
    pipe_d  = pipe_q;
    cnt_d   = cnt_q;
    if (wr_evt) stage_d = merged;
    if (cnt_q == CW'(1)) stage_d = pipe_q;
    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    if (fetch_go) begin
      pipe_d = fetch_data;
      cnt_d  = CW'(LAT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      pipe_q  <= '0;
      cnt_q   <= '0;
    end else begin
      stage_q <= stage_d;
      pipe_q  <= pipe_d;
      cnt_q   <= cnt_d;
    end
  end

  assign commit      = wr_evt & wr_addr[AW-1];
  assign commit_data = merged;
  assign hold_o      = (cnt_q != '0);
endmodule

// File: rtl/hq_regs.sv
module hq_regs
  import hq_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int IRQ_W = 8,
  parameter int IW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [QW-1:0]    wdata,
  input  logic [IW-1:0]    ridx,
  output logic [QW-1:0]    rdata,
  input  logic [IRQ_W-1:0] irq_set,
  output logic [QW-1:0]    irq_en,
  output logic             irq_n
);
  logic [QW-1:0] rbank [NREG];
  logic [QW-1:0] st_q, st_d, en_q, en_d, set_ext;

  always_comb begin
    set_ext = QW'(irq_set);
    st_d    = st_q;
    en_d    = en_q;
    if (we && widx == IW'(0)) st_d = st_q & ~wdata;
    st_d = st_d | set_ext;
    if (we && widx == IW'(1)) en_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_st
      assign rbank[i] = st_q;
    end else if (i == 1) begin : g_en
      assign rbank[i] = en_q;
    end else begin : g_mem
      logic [QW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   q <= '0;
        else if (we && widx == IW'(i)) q <= wdata;
      end
      assign rbank[i] = q;
    end
  end

  always_comb begin
    rdata = '0;
    if (32'(ridx) < NREG) rdata = rbank[ridx];
  end

  assign irq_en = en_q;
  assign irq_n  = ~|(st_q & en_q);
endmodule

// File: rtl/hostq_bridge.sv
module hostq_bridge
  import hq_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int IRQ_W = 8,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             ale,
  input  logic             wide_mode,
  input  logic             mux_mode,
  input  logic [7:0]       addr_lo,
  input  logic             addr_ctl,
  input  logic [15:0]      data_in,
  output logic [15:0]      data_out,
  output logic             data_oe,
  output logic             hold_o,
  input  logic [IRQ_W-1:0] irq_set,
  output logic             irq_n
);
  localparam int AW = 9;
  localparam int IW = AW - 3;

  logic          rst_s1_q, rst_s;
  logic [3:0]    sync_o;
  logic          cs_s, rd_s, wr_s, ale_s;
  logic [AW-1:0] addr_eff, wr_addr;
  logic          rd_evt, wr_evt, commit;
  logic [HW-1:0] wr_data;
  logic [QW-1:0] stage_q, commit_data, fetch_data, irq_en;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s    <= rst_s1_q;
    end
  end

  hq_sync #(.W(4), .RV(4'b0111)) u_sync (
    .clk(clk), .rst_n(rst_s), .din({ale, wr_n, rd_n, cs_n}), .dout(sync_o)
  );
  assign {ale_s, wr_s, rd_s, cs_s} = sync_o;

  hq_front #(.AW(AW), .DW(HW)) u_front (
    .clk(clk), .rst_n(rst_s), .cs_s(cs_s), .rd_s(rd_s), .wr_s(wr_s), .ale_s(ale_s),
    .mux_mode(mux_mode), .addr_lo(addr_lo), .addr_ctl(addr_ctl), .data_in(data_in),
    .addr_eff(addr_eff), .rd_evt(rd_evt), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  hq_stage #(.LAT(LAT), .AW(AW)) u_stage (
    .clk(clk), .rst_n(rst_s), .wide_mode(wide_mode), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .fetch_go(rd_evt & addr_eff[AW-1]), .fetch_data(fetch_data),
    .stage_q(stage_q), .commit(commit), .commit_data(commit_data), .hold_o(hold_o)
  );

  hq_regs #(.NREG(NREG), .IRQ_W(IRQ_W), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_s), .we(commit), .widx(wr_addr[AW-2:2]), .wdata(commit_data),
    .ridx(addr_eff[AW-2:2]), .rdata(fetch_data), .irq_set(irq_set), .irq_en(irq_en),
    .irq_n(irq_n)
  );

  assign data_out = lane_get(stage_q, wide_mode, addr_eff[1:0]);
  assign data_oe  = ~cs_n & ~rd_n & wr_n;
endmodule

// File: rtl/hq_chk.sv
module hq_chk #(
  parameter int IRQ_W = 8,
  parameter int LAT   = 2
) (
  input logic             clk,
  input logic             rst_s,
  input logic             cs_n,
  input logic             data_oe,
  input logic             hold_o,
  input logic             irq_n,
  input logic [IRQ_W-1:0] irq_set,
  input logic [31:0]      irq_en,
  input logic             rd_evt,
  input logic             wr_evt,
  input logic             cs_s,
  input logic             rd_s,
  input logic             wr_s
);
  logic [7:0] hcnt_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      hcnt_q <= '0;
    else if (hold_o) hcnt_q <= (hcnt_q == 8'hff) ? hcnt_q : hcnt_q + 8'd1;
    else             hcnt_q <= '0;
  end

  // R6
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_s)
    hold_o |-> (32'(hcnt_q) < LAT));

  // R6
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(hold_o) && !hold_o) |-> (32'(hcnt_q) == LAT));

  // R6
  hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(hold_o) |-> $past(rd_evt));

  // R7
  both_low_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!cs_s && !rd_s && !wr_s) |-> !rd_evt);

  // R9
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_s)
    cs_n |-> !data_oe);

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ((|(32'(irq_set) & irq_en)) && !wr_evt) |=> !irq_n);
endmodule

bind hostq_bridge hq_chk #(.IRQ_W(IRQ_W), .LAT(LAT)) u_chk (
  .clk(clk), .rst_s(rst_s), .cs_n(cs_n), .data_oe(data_oe), .hold_o(hold_o),
  .irq_n(irq_n), .irq_set(irq_set), .irq_en(irq_en), .rd_evt(rd_evt), .wr_evt(wr_evt),
  .cs_s(cs_s), .rd_s(rd_s), .wr_s(wr_s)
);

// File: tb/hostq_bridge_tb.sv
module hostq_bridge_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0;
  logic wide_mode = 1'b0, mux_mode = 1'b0, addr_ctl = 1'b0;
  logic [7:0] addr_lo = '0;
  logic [15:0] data_in = '0;
  logic [7:0] irq_set = '0;
  logic [15:0] data_out;
  logic data_oe, hold_o, irq_n;
  int total = 0, bad = 0, cycles = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  hostq_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ale(ale),
    .wide_mode(wide_mode), .mux_mode(mux_mode), .addr_lo(addr_lo), .addr_ctl(addr_ctl),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .hold_o(hold_o),
    .irq_set(irq_set), .irq_n(irq_n)
  );

  // [39]=wide [38]=mux [37:32]=index [31:0]=value
  localparam logic [39:0] VEC [6] = '{
    {1'b0, 1'b0, 6'd2,  32'hA1B2C3D4},
    {1'b1, 1'b0, 6'd3,  32'h55667788},
    {1'b0, 1'b1, 6'd4,  32'hDEADBEEF},
    {1'b1, 1'b1, 6'd5,  32'h0F0E0D0C},
    {1'b0, 1'b0, 6'd15, 32'hFFFFFFFF},
    {1'b1, 1'b0, 6'd9,  32'h00000001}
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_addr(input logic [8:0] a);
    addr_ctl = a[8];
    if (mux_mode) begin
      data_in = {8'h00, a[7:0]};
      ale = 1'b1; cyc(3);
      ale = 1'b0; cyc(3);
    end else addr_lo = a[7:0];
  endtask

  task automatic bus_wr(input logic [8:0] a, input logic [15:0] d, input logic both,
                        input logic no_cs);
    put_addr(a);
    data_in = d;
    cs_n = no_cs; cyc(1);
    wr_n = 1'b0; rd_n = ~both; cyc(4);
    if (both) chk("R7 oe off", {31'd0, data_oe}, 32'd0);
    wr_n = 1'b1; rd_n = 1'b1; cyc(4);
    cs_n = 1'b1; cyc(3);
  endtask

  task automatic bus_rd(input logic [8:0] a, output logic [15:0] d, output int hc);
    put_addr(a);
    cs_n = 1'b0; rd_n = 1'b0;
    hc = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (hold_o) hc++;
    end
    d = data_out;
    rd_n = 1'b1; cs_n = 1'b1; cyc(3);
  endtask

  task automatic wq(input logic [5:0] idx, input logic [31:0] v, input logic both);
    if (wide_mode) begin
      bus_wr({1'b0, idx, 2'b00}, v[15:0], both, 1'b0);
      bus_wr({1'b1, idx, 2'b10}, v[31:16], both, 1'b0);
    end else begin
      for (int b = 0; b < 4; b++)
        bus_wr({(b == 3), idx, 2'(b)}, {8'h00, v[8*b +: 8]}, both, 1'b0);
    end
  endtask

  task automatic rq(input logic [5:0] idx, output logic [31:0] v, output int hc);
    logic [15:0] d;
    int h;
    if (wide_mode) begin
      bus_rd({1'b1, idx, 2'b00}, d, hc); v[15:0] = d;
      bus_rd({1'b0, idx, 2'b10}, d, h);  v[31:16] = d;
    end else begin
      for (int b = 0; b < 4; b++) begin
        bus_rd({(b == 0), idx, 2'(b)}, d, h);
        if (b == 0) hc = h;
        v[8*b +: 8] = d[7:0];
        chk("R2 upper zero", {16'h0, d[15:8], 8'h0}, 32'd0);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] d;
    int hc;
    cyc(3);
    // R1 reset state
    chk("R1 hold", {31'd0, hold_o}, 32'd0);
    chk("R1 irq", {31'd0, irq_n}, 32'd1);
    chk("R1 oe", {31'd0, data_oe}, 32'd0);
    rst_n = 1'b1; cyc(4);
    rq(6'd7, v, hc);
    chk("R1 reg zero", v, 32'd0);

    // R2 R3 R4 R5 R6: quadlet round trips in each mode
    for (int i = 0; i < 6; i++) begin
      wide_mode = VEC[i][39]; mux_mode = VEC[i][38];
      wq(VEC[i][37:32], VEC[i][31:0], 1'b0);
      rq(VEC[i][37:32], v, hc);
      chk(VEC[i][39] ? (VEC[i][38] ? "R3 R4 wide mux" : "R3 wide") :
          (VEC[i][38] ? "R4 mux" : "R2 narrow"), v, VEC[i][31:0]);
      chk("R6 hold length", 32'(hc), 32'd2);
    end
    wide_mode = 1'b0; mux_mode = 1'b0;

    // R5: writes without addr_ctl leave the bank alone
    for (int b = 0; b < 4; b++) bus_wr({1'b0, 6'd2, 2'(b)}, 16'h0099, 1'b0, 1'b0);
    rq(6'd2, v, hc);
    chk("R5 no commit", v, 32'hA1B2C3D4);
    // R5: unimplemented index
    wq(6'd40, 32'h12345678, 1'b0);
    rq(6'd40, v, hc);
    chk("R5 unimplemented", v, 32'd0);

    // R6: read without addr_ctl returns staging, no fetch
    rq(6'd4, v, hc);
    bus_rd({1'b0, 6'd9, 2'b01}, d, hc);
    chk("R6 staging lane", {16'h0, d}, 32'h000000BE);
    chk("R6 no hold", 32'(hc), 32'd0);

    // R7: both strobes low is a write
    wq(6'd10, 32'hCAFEF00D, 1'b1);
    rq(6'd10, v, hc);
    chk("R7 both low write", v, 32'hCAFEF00D);

    // R8: drive enable only during read
    put_addr(9'h000);
    cs_n = 1'b0; rd_n = 1'b0; cyc(1);
    chk("R8 oe on", {31'd0, data_oe}, 32'd1);
    wr_n = 1'b0; #0.1;
    chk("R8 oe off with wr", {31'd0, data_oe}, 32'd0);
    wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1; cyc(3);

    // R9: strobes ignored without chip select
    bus_wr({1'b1, 6'd3, 2'b11}, 16'h00AA, 1'b0, 1'b1);
    rq(6'd3, v, hc);
    chk("R9 ignored write", v, 32'h55667788);
    cs_n = 1'b1; rd_n = 1'b0; cyc(1);
    chk("R9 oe off", {31'd0, data_oe}, 32'd0);
    rd_n = 1'b1; cyc(3);

    // R10: interrupt set, mask and write-one-to-clear
    wq(6'd1, 32'h00000005, 1'b0);
    irq_set = 8'h02; cyc(1); irq_set = 8'h00; cyc(1);
    chk("R10 masked", {31'd0, irq_n}, 32'd1);
    irq_set = 8'h04; cyc(1); irq_set = 8'h00; cyc(1);
    chk("R10 asserted", {31'd0, irq_n}, 32'd0);
    rq(6'd0, v, hc);
    chk("R10 status", v, 32'h00000006);
    wq(6'd0, 32'h00000004, 1'b0);
    chk("R10 cleared", {31'd0, irq_n}, 32'd1);
    rq(6'd0, v, hc);
    chk("R10 status kept", v, 32'h00000002);

    // R11: asynchronous reset mid-fetch
    irq_set = 8'h01; cyc(1); irq_set = 8'h00; cyc(1);
    put_addr({1'b1, 6'd2, 2'b00});
    cs_n = 1'b0; rd_n = 1'b0; cyc(3);
    @(negedge clk); #0.5;
    rst_n = 1'b0; #0.5;
    chk("R11 hold", {31'd0, hold_o}, 32'd0);
    chk("R11 irq", {31'd0, irq_n}, 32'd1);
    rd_n = 1'b1; cs_n = 1'b1;
    cyc(2); rst_n = 1'b1; cyc(4);
    rq(6'd2, v, hc);
    chk("R11 bank cleared", v, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule